// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits at the instruction boundary of a small 16-bit microprogrammed processor. Each time the current instruction finishes, it chooses between starting the next instruction fetch and taking an external interrupt. When it takes an interrupt, it runs the acknowledge handshake and then the entry sequence. The entry sequence saves the status word and then the program counter onto the stack, one byte at a time through a byte-wide memory write port. It then clears the flags and loads the program counter from the interrupt vector.

A software trap opcode, whose upper four bits are all ones, runs the same entry sequence with no handshake. The register file stays outside the block and is reached through plain ports. The block reads the stack pointer and asks for it to be incremented. It requests the flag clear and the program-counter load, and the register file carries them out. Clearing the flags also clears the interrupt-enable bit held in the status word, so after entry the next boundary goes straight to fetch.

Top module: `irq_entry_seq`

## Requirements
- R1: At a boundary (`boundary_i`=1) with `ie_i`=0, `fetch_go_o` is 1 in that same cycle, `inta_o` stays 0 whatever `int_i` is, and no entry sequence starts.
- R2: At a boundary with `ie_i`=1 and `int_i`=0, `fetch_go_o` is 1 in that same cycle and `inta_o` stays 0.
- R3: At a boundary with `ie_i`=1 and `int_i`=1, `inta_o` is 1 in that cycle and `fetch_go_o` is 0. `inta_o` stays 1 in every later cycle in which `int_i` is still 1. In the first cycle with `int_i`=0, `inta_o` is 0 and the entry sequence starts, with its first byte write in the next cycle.
- R4: On every cycle in which `inta_o` is 1, `vec_i` is captured. The last value captured is the one later loaded into the program counter.
- R5: The entry sequence writes exactly four bytes, in this order: status bits 7:0, status bits 15:8, program counter bits 7:0, program counter bits 15:8. Each byte goes to the address currently on `sp_i`.
- R6: `sp_inc_o` is 1 for exactly one cycle, in the cycle right after each byte is accepted. The sequence makes four increments in total.
- R7: A byte write (`mem_we_o`=1) is accepted in the cycle in which `mem_wait_i` is 0. While `mem_wait_i` is 1, the write enable, address and data hold their values into the next cycle.
- R8: In the cycle after the fourth increment, `pc_load_o`, `flags_clr_o` and `done_o` are all 1 for one cycle only, with `pc_val_o` equal to the held vector. The block is then idle.
- R9: With `trap_valid_i`=1, `op_tag_i`=4'b1111 and no boundary, in the idle state, the entry sequence starts without `inta_o`, whatever `ie_i` and `int_i` are. The held vector is used.
- R10: A trap request whose `op_tag_i` is not 4'b1111 is ignored: no write, no load and no fetch pulse follow.
- R11: The status word and program counter are captured in the cycle the sequence starts. Later changes on `status_i` and `pc_i` do not alter the bytes written.
- R12: While a sequence is running, `boundary_i`, `trap_valid_i` and `int_i` are ignored: `fetch_go_o` and `inta_o` stay 0 and the sequence is not restarted.
- R13: During and right after reset every output is 0 and the held vector is 0. A trap taken before any acknowledge therefore loads program counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Current instruction has finished; decide this cycle |
| ie_i | input | 1 | Interrupt-enable bit of the status word |
| int_i | input | 1 | External interrupt request |
| inta_o | output | 1 | Interrupt acknowledge |
| vec_i | input | 16 | Interrupt vector from the requester |
| trap_valid_i | input | 1 | A decoded opcode is presented for trap detection |
| op_tag_i | input | 4 | Upper four opcode bits; 1111 marks the trap |
| fetch_go_o | output | 1 | Start the next instruction fetch |
| status_i | input | 16 | Current status word |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| sp_inc_o | output | 1 | Increment the stack pointer |
| flags_clr_o | output | 1 | Clear all flags, interrupt enable included |
| pc_load_o | output | 1 | Load the program counter from pc_val_o |
| pc_val_o | output | 16 | New program counter value |
| mem_we_o | output | 1 | Byte write request |
| mem_addr_o | output | 16 | Byte write address |
| mem_data_o | output | 8 | Byte write data |
| mem_wait_i | input | 1 | Memory not ready; hold the write |
| done_o | output | 1 | Entry finished, program counter loaded |

## Verification
The bench holds the interrupt request for random lengths while changing the vector every cycle. A design that latched only the first vector, or the one present after release, would load the wrong program counter. Random memory stalls stress the write path. A design that advanced the stack pointer during a stall, or changed the address mid-write, would show up as a mismatched address or an increment that does not follow an accepted byte. The status and program-counter inputs are scrambled throughout the sequence, which catches a design that reads them live. Boundaries, interrupts and traps are injected while the block is busy, which catches one that restarts or pulses fetch mid-entry. A trap taken straight after reset checks that the vector register is cleared.

// File: rtl/irq_entry_pkg.sv
// Shared state encodings for the interrupt entry sequencer.
package irq_entry_pkg;

    // Boundary gate: waiting, acknowledging, or handing over to the pusher.
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_ACK  = 2'd1,
        GATE_BUSY = 2'd2
    } gate_state_t;

    // Push engine: idle, byte write (held on wait), SP step, PC load.
    typedef enum logic [1:0] {
        PUSH_IDLE  = 2'd0,
        PUSH_WRITE = 2'd1,
        PUSH_STEP  = 2'd2,
        PUSH_LOAD  = 2'd3
    } push_state_t;

endpackage

// File: rtl/irq_gate.sv
// Boundary decision and acknowledge handshake.
// What: at each boundary, fetch or acknowledge; keep acknowledging while the
// request stays high and latch the vector each such cycle; start the entry
// sequence on release, or at once on a trap tag in idle.
// Assumes: boundary_i takes priority over a trap request in the same cycle;
// seq_done_i pulses once at the end of each started sequence.
module irq_gate
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              ie_i,
    input  logic              int_i,
    input  logic              trap_valid_i,
    input  logic [TAG_W-1:0]  op_tag_i,
    input  logic [DATA_W-1:0] vec_i,
    input  logic              seq_done_i,
    output logic              inta_o,
    output logic              fetch_go_o,
    output logic              start_o,
    output logic [DATA_W-1:0] vec_o
);

    localparam logic [TAG_W-1:0] TRAP_TAG = {TAG_W{1'b1}};

    gate_state_t       state_q, state_d;
    logic [DATA_W-1:0] vec_q;
    logic              trap_hit;

    // Trap detection on the opcode tag.
    assign trap_hit = trap_valid_i && (op_tag_i == TRAP_TAG);

    // Next-state and per-cycle outputs of the gate.
    always_comb begin
        state_d    = state_q;
        inta_o     = 1'b0;
        fetch_go_o = 1'b0;
        start_o    = 1'b0;
        unique case (state_q)
            GATE_IDLE: begin
                if (boundary_i) begin
                    if (ie_i && int_i) begin
                        inta_o  = 1'b1;
                        state_d = GATE_ACK;
                    end else begin
                        fetch_go_o = 1'b1;
                    end
                end else if (trap_hit) begin
                    start_o = 1'b1;
                    state_d = GATE_BUSY;
                end
            end
            GATE_ACK: begin
                if (int_i) begin
                    inta_o = 1'b1;
                end else begin
                    start_o = 1'b1;
                    state_d = GATE_BUSY;
                end
            end
            GATE_BUSY: begin
                if (seq_done_i) begin
                    state_d = GATE_IDLE;
                end
            end
            default: state_d = GATE_IDLE;
        endcase
    end

    // State register and vector capture on every acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (inta_o) begin
                vec_q <= vec_i;
            end
        end
    end

    assign vec_o = vec_q;

endmodule

// File: rtl/byte_selector.sv
// Byte lane picker.
// What: splits a frame into byte lanes, lane 0 at the least significant end,
// and returns the lane named by sel_i.
// Assumes: sel_i is below LANES.
module byte_selector #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int IDX_W  = 2
) (
    input  logic [LANES*BYTE_W-1:0] frame_i,
    input  logic [IDX_W-1:0]        sel_i,
    output logic [BYTE_W-1:0]       byte_o
);

    logic [BYTE_W-1:0] lane [LANES];

    // One slice per lane.
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign lane[g] = frame_i[g*BYTE_W +: BYTE_W];
        end
    endgenerate

    // Lane mux.
    assign byte_o = lane[sel_i];

endmodule

// File: rtl/push_sequencer.sv
// Stack push and vector load engine.
// What: on start, snapshots status and PC, writes them low byte first to the
// address on sp_i (status first), requests one SP increment after each
// accepted byte, then clears the flags and loads the PC from vec_i.
// Assumes: sp_i changes only in response to sp_inc_o; vec_i is stable while
// a sequence runs.
module push_sequencer
    import irq_entry_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    input  logic [DATA_W-1:0] vec_i,
    input  logic              mem_wait_i,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_data_o,
    output logic              sp_inc_o,
    output logic              flags_clr_o,
    output logic              pc_load_o,
    output logic [DATA_W-1:0] pc_val_o,
    output logic              done_o
);

    localparam int BYTES_PER_WORD = DATA_W / BYTE_W;
    localparam int TOTAL_BYTES    = 2 * BYTES_PER_WORD;
    localparam int IDX_W          = $clog2(TOTAL_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_BYTES - 1);

    push_state_t         state_q, state_d;
    logic [2*DATA_W-1:0] frame_q;
    logic [IDX_W-1:0]    idx_q;
    logic [BYTE_W-1:0]   cur_byte;

    // Current byte of the snapshot frame.
    byte_selector #(
        .BYTE_W (BYTE_W),
        .LANES  (TOTAL_BYTES),
        .IDX_W  (IDX_W)
    ) u_pick (
        .frame_i (frame_q),
        .sel_i   (idx_q),
        .byte_o  (cur_byte)
    );

    // Next-state and per-cycle strobes of the engine.
    always_comb begin
        state_d     = state_q;
        mem_we_o    = 1'b0;
        sp_inc_o    = 1'b0;
        flags_clr_o = 1'b0;
        pc_load_o   = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            PUSH_IDLE: begin
                if (start_i) begin
                    state_d = PUSH_WRITE;
                end
            end
            PUSH_WRITE: begin
                mem_we_o = 1'b1;
                if (!mem_wait_i) begin
                    state_d = PUSH_STEP;
                end
            end
            PUSH_STEP: begin
                sp_inc_o = 1'b1;
                state_d  = (idx_q == LAST_IDX) ? PUSH_LOAD : PUSH_WRITE;
            end
            PUSH_LOAD: begin
                flags_clr_o = 1'b1;
                pc_load_o   = 1'b1;
                done_o      = 1'b1;
                state_d     = PUSH_IDLE;
            end
            default: state_d = PUSH_IDLE;
        endcase
    end

    // State, byte index and snapshot registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PUSH_IDLE;
            idx_q   <= '0;
            frame_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == PUSH_IDLE && start_i) begin
                frame_q <= {pc_i, status_i};
            end
            if (state_q == PUSH_STEP) begin
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
            end
        end
    end

    assign mem_addr_o = mem_we_o ? sp_i : '0;
    assign mem_data_o = mem_we_o ? cur_byte : '0;
    assign pc_val_o   = pc_load_o ? vec_i : '0;

endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt acknowledge and entry sequencer, top level.
// What: joins the boundary gate to the push engine; the gate's held vector
// feeds the PC load and the engine's done pulse releases the gate.
// Assumes: the register file applies sp_inc_o, flags_clr_o and pc_load_o in
// the cycle they are raised.
module irq_entry_seq #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              ie_i,
    input  logic              int_i,
    output logic              inta_o,
    input  logic [DATA_W-1:0] vec_i,
    input  logic              trap_valid_i,
    input  logic [TAG_W-1:0]  op_tag_i,
    output logic              fetch_go_o,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] pc_i,
    input  logic [DATA_W-1:0] sp_i,
    output logic              sp_inc_o,
    output logic              flags_clr_o,
    output logic              pc_load_o,
    output logic [DATA_W-1:0] pc_val_o,
    output logic              mem_we_o,
    output logic [DATA_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_data_o,
    input  logic              mem_wait_i,
    output logic              done_o
);

    logic              seq_start;
    logic [DATA_W-1:0] vec_held;

    // Boundary decision and handshake.
    irq_gate #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .boundary_i   (boundary_i),
        .ie_i         (ie_i),
        .int_i        (int_i),
        .trap_valid_i (trap_valid_i),
        .op_tag_i     (op_tag_i),
        .vec_i        (vec_i),
        .seq_done_i   (done_o),
        .inta_o       (inta_o),
        .fetch_go_o   (fetch_go_o),
        .start_o      (seq_start),
        .vec_o        (vec_held)
    );

    // Stack pushes and vector load.
    push_sequencer #(
        .DATA_W (DATA_W),
        .BYTE_W (BYTE_W)
    ) u_push (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (seq_start),
        .status_i    (status_i),
        .pc_i        (pc_i),
        .sp_i        (sp_i),
        .vec_i       (vec_held),
        .mem_wait_i  (mem_wait_i),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_o  (mem_data_o),
        .sp_inc_o    (sp_inc_o),
        .flags_clr_o (flags_clr_o),
        .pc_load_o   (pc_load_o),
        .pc_val_o    (pc_val_o),
        .done_o      (done_o)
    );

endmodule

// File: rtl/irq_entry_seq_chk.sv
// Protocol checker for irq_entry_seq, attached by bind.
// What: port-level timing rules of the handshake, the write port and the
// completion strobes.
// Assumes: synchronous active-low reset held for at least one clock.
module irq_entry_seq_chk #(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_i,
    input logic              inta_o,
    input logic              fetch_go_o,
    input logic              mem_we_o,
    input logic              mem_wait_i,
    input logic [DATA_W-1:0] mem_addr_o,
    input logic [BYTE_W-1:0] mem_data_o,
    input logic              sp_inc_o,
    input logic              pc_load_o,
    input logic              flags_clr_o,
    input logic              done_o
);

    // R3
    inta_needs_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_o |-> int_i);

    // R1
    fetch_not_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go_o |-> !inta_o);

    // R7
    write_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_wait_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    // R6
    inc_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_inc_o |-> $past(mem_we_o && !mem_wait_i));

    // R8
    load_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (done_o && flags_clr_o));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R12
    phases_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, sp_inc_o, pc_load_o, fetch_go_o, inta_o}));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
) u_chk (.*);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        boundary_i, ie_i, int_i, trap_valid_i, mem_wait_i;
    logic [3:0]  op_tag_i;
    logic [15:0] vec_i, status_i, pc_i, sp_i;
    logic        inta_o, fetch_go_o, sp_inc_o, flags_clr_o, pc_load_o, mem_we_o, done_o;
    logic [15:0] pc_val_o, mem_addr_o;
    logic [7:0]  mem_data_o;

    logic        sp_set;
    logic [15:0] sp_set_val, sp_q;
    logic [15:0] held_vec;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    // Register-file model of the stack pointer.
    always @(posedge clk) begin
        if (sp_set) sp_q <= sp_set_val;
        else if (sp_inc_o) sp_q <= sp_q + 16'd1;
    end
    assign sp_i = sp_q;

    irq_entry_seq dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ie_i(ie_i), .int_i(int_i),
        .inta_o(inta_o), .vec_i(vec_i), .trap_valid_i(trap_valid_i), .op_tag_i(op_tag_i),
        .fetch_go_o(fetch_go_o), .status_i(status_i), .pc_i(pc_i), .sp_i(sp_i),
        .sp_inc_o(sp_inc_o), .flags_clr_o(flags_clr_o), .pc_load_o(pc_load_o),
        .pc_val_o(pc_val_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .mem_wait_i(mem_wait_i), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected byte number k of the push: status low/high, then PC low/high.
    function automatic logic [7:0] exp_byte(input int k, input logic [15:0] st, input logic [15:0] pc);
        case (k)
            0:       return st[7:0];
            1:       return st[15:8];
            2:       return pc[7:0];
            default: return pc[15:8];
        endcase
    endfunction

    task automatic drive_idle();
        boundary_i = 0; ie_i = 0; int_i = 0; trap_valid_i = 0; op_tag_i = 0; mem_wait_i = 0;
    endtask

    task automatic set_sp(input logic [15:0] v);
        @(posedge clk); #1 sp_set = 1; sp_set_val = v;
        @(posedge clk); #1 sp_set = 0;
    endtask

    // Follows a sequence from the cycle after start up to the PC load.
    task automatic run_push(input logic [15:0] exp_vec, input logic [15:0] st, input logic [15:0] pc,
                            input bit stall, input bit poke);
        int acc = 0;
        int inc = 0;
        bit prev_acc = 0;
        bit fin = 0;
        logic [15:0] sp0 = sp_q;
        for (int c = 0; c < 400 && !fin; c++) begin
            @(posedge clk); #1;
            mem_wait_i = stall ? (($urandom % 3) == 0) : 1'b0;
            status_i = $urandom; pc_i = $urandom;            // R11 scramble
            if (poke) begin                                  // R12 stray requests
                boundary_i = $urandom % 2; trap_valid_i = $urandom % 2;
                op_tag_i = $urandom; ie_i = $urandom % 2; int_i = $urandom % 2;
            end else begin
                boundary_i = 0; trap_valid_i = 0; int_i = 0;
            end
            @(negedge clk);
            check(inta_o == 0, "R12 inta while busy", inta_o, 0);
            check(fetch_go_o == 0, "R12 fetch while busy", fetch_go_o, 0);
            if (sp_inc_o) begin
                check(prev_acc, "R6 increment not after accept", prev_acc, 1);
                inc++;
            end
            prev_acc = mem_we_o && !mem_wait_i;
            if (mem_we_o) begin
                check(mem_addr_o == sp0 + 16'(acc), "R5 address", mem_addr_o, sp0 + 16'(acc));
                check(mem_data_o == exp_byte(acc, st, pc), "R5 R11 byte", mem_data_o, exp_byte(acc, st, pc));
                if (!mem_wait_i) acc++;                      // R7 accepted only without wait
            end
            if (pc_load_o) begin
                check(pc_val_o == exp_vec, "R8 R4 vector", pc_val_o, exp_vec);
                check(done_o && flags_clr_o, "R8 strobes", {done_o, flags_clr_o}, 2'b11);
                check(inc == 4, "R6 increment count", inc, 4);
                check(acc == 4, "R5 byte count", acc, 4);
                fin = 1;
            end
        end
        if (!fin) check(0, "R8 no load", 0, 1);
        @(posedge clk); #1 drive_idle();
        @(negedge clk);
        check(!done_o && !pc_load_o && !mem_we_o, "R8 single cycle", {done_o, pc_load_o, mem_we_o}, 0);
    endtask

    task automatic do_irq(input int hold, input bit stall, input bit poke);
        logic [15:0] last_vec, st, pc;
        set_sp($urandom);
        @(posedge clk); #1;
        boundary_i = 1; ie_i = 1; int_i = 1; vec_i = $urandom; last_vec = vec_i;
        @(negedge clk);
        check(inta_o == 1, "R3 inta at boundary", inta_o, 1);
        check(fetch_go_o == 0, "R3 no fetch", fetch_go_o, 0);
        for (int k = 0; k < hold; k++) begin
            @(posedge clk); #1;
            boundary_i = 0; vec_i = $urandom; last_vec = vec_i;
            @(negedge clk);
            check(inta_o == 1, "R3 inta repeated", inta_o, 1);
            check(mem_we_o == 0, "R3 no write during ack", mem_we_o, 0);
        end
        @(posedge clk); #1;
        boundary_i = 0; int_i = 0; vec_i = $urandom;
        status_i = $urandom; pc_i = $urandom; st = status_i; pc = pc_i;
        @(negedge clk);
        check(inta_o == 0, "R3 inta released", inta_o, 0);
        check(mem_we_o == 0, "R3 write waits one cycle", mem_we_o, 0);
        held_vec = last_vec;
        run_push(last_vec, st, pc, stall, poke);
    endtask

    task automatic do_trap(input bit stall, input bit poke);
        logic [15:0] st, pc;
        set_sp($urandom);
        @(posedge clk); #1;
        trap_valid_i = 1; op_tag_i = 4'hF; ie_i = $urandom % 2; int_i = $urandom % 2;
        boundary_i = 0; vec_i = $urandom;
        status_i = $urandom; pc_i = $urandom; st = status_i; pc = pc_i;
        @(negedge clk);
        check(inta_o == 0, "R9 no inta on trap", inta_o, 0);
        check(fetch_go_o == 0, "R9 no fetch on trap", fetch_go_o, 0);
        run_push(held_vec, st, pc, stall, poke);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 0; drive_idle(); vec_i = 0; status_i = 0; pc_i = 0;
        sp_set = 1; sp_set_val = 16'h0100; held_vec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({inta_o, fetch_go_o, sp_inc_o, flags_clr_o, pc_load_o, mem_we_o, done_o} == 0,
              "R13 reset outputs", {inta_o, fetch_go_o, mem_we_o, done_o}, 0);
        @(posedge clk); #1 rst_n = 1; sp_set = 0;
        @(negedge clk);
        check({inta_o, mem_we_o, pc_load_o} == 0, "R13 after reset", {inta_o, mem_we_o, pc_load_o}, 0);

        // R13: trap before any acknowledge loads vector 0
        do_trap(0, 0);

        // R1: enable off, request high
        @(posedge clk); #1 boundary_i = 1; ie_i = 0; int_i = 1;
        @(negedge clk);
        check(fetch_go_o == 1, "R1 fetch", fetch_go_o, 1);
        check(inta_o == 0, "R1 no inta", inta_o, 0);
        @(posedge clk); #1 boundary_i = 0;
        @(negedge clk);
        check(inta_o == 0 && mem_we_o == 0, "R1 no entry", {inta_o, mem_we_o}, 0);

        // R2: enable on, request low
        @(posedge clk); #1 boundary_i = 1; ie_i = 1; int_i = 0;
        @(negedge clk);
        check(fetch_go_o == 1, "R2 fetch", fetch_go_o, 1);
        check(inta_o == 0, "R2 no inta", inta_o, 0);
        @(posedge clk); #1 drive_idle();

        // R10: non-trap tags ignored
        for (int t = 0; t < 15; t++) begin
            @(posedge clk); #1 trap_valid_i = 1; op_tag_i = 4'(t);
            @(posedge clk); #1 trap_valid_i = 0;
            for (int w = 0; w < 3; w++) begin
                @(negedge clk);
                check(!mem_we_o && !pc_load_o && !fetch_go_o && !inta_o, "R10 tag ignored",
                      {mem_we_o, pc_load_o, fetch_go_o}, 0);
                @(posedge clk); #1;
            end
        end

        // Directed: minimum hold, no stall; long hold with stalls (R4 R7)
        do_irq(0, 0, 0);
        do_irq(6, 1, 0);
        // R9 after a real acknowledge: held vector reused
        do_trap(1, 0);

        // Random mix with stray requests while busy (R12)
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 3 == 0) do_trap($urandom % 2, $urandom % 2);
            else do_irq($urandom % 5, $urandom % 2, $urandom % 2);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule